// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for a five-stage in-order integer pipeline, where each operand of an instruction should come from: the register file, or a result that has been computed but not yet written back. It compares source register numbers against the destination numbers and write enables of the two instructions ahead. From that comparison it drives 2-bit mux selects.

Two pairs of selects are produced. The execute pair steers the two ALU operand muxes, using the source numbers of the instruction now in execute. The decode pair steers the inputs of an early equality comparator that resolves branches in decode, using the source numbers of the instruction now in decode.

Both pairs apply the same rules. Register 0 is never forwarded. When both later stages hold a matching producer, the younger result, held in the execute/memory register, wins. The logic is purely combinational, so a select follows its inputs within the same cycle. The pipeline registers, the ALU and the register file are outside the block.

Top module: `fwd_unit`

## Requirements
- R1: A source equal to the execute/memory destination selects 2'b10 when that stage's write enable is high and its destination is nonzero.
- R2: A source equal to the memory/writeback destination selects 2'b01 when that stage's write enable is high, its destination is nonzero and the R1 condition does not hold for the same source.
- R3: When both stages satisfy their match condition for one source, the select is 2'b10: the younger execute/memory result wins.
- R4: A stage whose write enable is low never causes forwarding. A matching older stage with its write enable high still forwards with 2'b01.
- R5: A destination of register 0 never causes forwarding, even when the source is also 0 and the write enable is high.
- R6: The decode selects (`id_sel_a` for `id_src_a`, `id_sel_b` for `id_src_b`) follow R1 to R5 against the same two producer stages.
- R7: With no qualifying match a select is 2'b00, which passes the register-file value. The value 2'b11 is never produced on any select.
- R8: Each select depends only on its own source number. Changing one source leaves the other three selects unchanged.
- R9: All selects are combinational and settle within the same cycle in which their inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the instruction in execute |
| ex_src_b | input | 5 | Second source register of the instruction in execute |
| id_src_a | input | 5 | First source register of the branch in decode |
| id_src_b | input | 5 | Second source register of the branch in decode |
| em_wr | input | 1 | Write enable held in the execute/memory register |
| em_dst | input | 5 | Destination register held in the execute/memory register |
| mw_wr | input | 1 | Write enable held in the memory/writeback register |
| mw_dst | input | 5 | Destination register held in the memory/writeback register |
| ex_sel_a | output | 2 | Mux select for ALU operand A (00 register file, 01 writeback, 10 memory stage) |
| ex_sel_b | output | 2 | Mux select for ALU operand B, same encoding |
| id_sel_a | output | 2 | Mux select for branch comparator input A, same encoding |
| id_sel_b | output | 2 | Mux select for branch comparator input B, same encoding |

## Verification
The hardest case to reach is the one where both producer stages name the same nonzero register as one source, both with the write enable high. Random 5-bit numbers make this a rare event. The stimulus therefore draws register numbers from a pool of four values, so that the two destinations and the four sources collide often. Directed cases add the extra conditions that randomness rarely combines on purpose: a double match where only the older stage writes, and a double match on register 0.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source select encoding
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,  // register file value
    SEL_WB   = 2'b01,  // memory/writeback stage value
    SEL_MEM  = 2'b10   // execute/memory stage value (younger)
  } fwd_sel_e;

endpackage

// File: rtl/fwd_match_cmp.sv
module fwd_match_cmp #(
  parameter int REG_AW = 5
) (
  input  logic              wr_en,
  input  logic [REG_AW-1:0] dst,
  input  logic [REG_AW-1:0] src,
  output logic              hit
);

  logic dst_nonzero;
  logic same_reg;

  always_comb begin
    dst_nonzero = |dst;
    same_reg    = (dst == src);
    hit         = wr_en & dst_nonzero & same_reg;
  end

endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel
  import fwd_pkg::*;
(
  input  logic     young_hit,
  input  logic     old_hit,
  output fwd_sel_e sel
);

  always_comb begin
    if (young_hit)    sel = SEL_MEM;
    else if (old_hit) sel = SEL_WB;
    else              sel = SEL_RF;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              em_wr,
  input  logic [REG_AW-1:0] em_dst,
  input  logic              mw_wr,
  input  logic [REG_AW-1:0] mw_dst,
  output logic [1:0]        ex_sel_a,
  output logic [1:0]        ex_sel_b,
  output logic [1:0]        id_sel_a,
  output logic [1:0]        id_sel_b
);

  localparam int NUM_SRC = 4;

  logic [REG_AW-1:0] src_vec   [NUM_SRC];
  logic              young_hit [NUM_SRC];
  logic              old_hit   [NUM_SRC];
  fwd_sel_e          sel_vec   [NUM_SRC];

  always_comb begin
    src_vec[0] = ex_src_a;
    src_vec[1] = ex_src_b;
    src_vec[2] = id_src_a;
    src_vec[3] = id_src_b;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_match_cmp #(.REG_AW(REG_AW)) u_young (
      .wr_en (em_wr),
      .dst   (em_dst),
      .src   (src_vec[g]),
      .hit   (young_hit[g])
    );

    fwd_match_cmp #(.REG_AW(REG_AW)) u_old (
      .wr_en (mw_wr),
      .dst   (mw_dst),
      .src   (src_vec[g]),
      .hit   (old_hit[g])
    );

    fwd_prio_sel u_prio (
      .young_hit (young_hit[g]),
      .old_hit   (old_hit[g]),
      .sel       (sel_vec[g])
    );
  end

  always_comb begin
    ex_sel_a = sel_vec[0];
    ex_sel_b = sel_vec[1];
    id_sel_a = sel_vec[2];
    id_sel_b = sel_vec[3];
  end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] ex_src_a,
  input logic [REG_AW-1:0] ex_src_b,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              em_wr,
  input logic [REG_AW-1:0] em_dst,
  input logic              mw_wr,
  input logic [REG_AW-1:0] mw_dst,
  input logic [1:0]        ex_sel_a,
  input logic [1:0]        ex_sel_b,
  input logic [1:0]        id_sel_a,
  input logic [1:0]        id_sel_b
);

  logic [REG_AW-1:0] srcs [4];
  logic [1:0]        sels [4];

  always_comb begin
    srcs[0] = ex_src_a; sels[0] = ex_sel_a;
    srcs[1] = ex_src_b; sels[1] = ex_sel_b;
    srcs[2] = id_src_a; sels[2] = id_sel_a;
    srcs[3] = id_src_b; sels[3] = id_sel_b;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      // R7
      sel_never_three_chk: assert (sels[i] != 2'b11)
        else $error("select %0d is 2'b11", i);
      // R1
      mem_sel_source_chk: assert (sels[i] != 2'b10 || (em_wr && em_dst != '0 && em_dst == srcs[i]))
        else $error("select %0d picks memory stage without a qualifying match", i);
      // R2
      wb_sel_source_chk: assert (sels[i] != 2'b01 ||
                                 (mw_wr && mw_dst != '0 && mw_dst == srcs[i] &&
                                  !(em_wr && em_dst != '0 && em_dst == srcs[i])))
        else $error("select %0d picks writeback stage without a qualifying match", i);
      // R5
      zero_src_no_fwd_chk: assert (srcs[i] != '0 || sels[i] == 2'b00)
        else $error("select %0d forwards register 0", i);
      // R4
      idle_stages_no_fwd_chk: assert (em_wr || mw_wr || sels[i] == 2'b00)
        else $error("select %0d forwards with both write enables low", i);
    end
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .ex_src_a (ex_src_a),
  .ex_src_b (ex_src_b),
  .id_src_a (id_src_a),
  .id_src_b (id_src_b),
  .em_wr    (em_wr),
  .em_dst   (em_dst),
  .mw_wr    (mw_wr),
  .mw_dst   (mw_dst),
  .ex_sel_a (ex_sel_a),
  .ex_sel_b (ex_sel_b),
  .id_sel_a (id_sel_a),
  .id_sel_b (id_sel_b)
);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ex_src_a = '0, ex_src_b = '0, id_src_a = '0, id_src_b = '0;
  logic          em_wr = 1'b0, mw_wr = 1'b0;
  logic [AW-1:0] em_dst = '0, mw_dst = '0;
  logic [1:0]    ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fwd_unit #(.REG_AW(AW)) u_dut (
    .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
    .id_src_a (id_src_a), .id_src_b (id_src_b),
    .em_wr (em_wr), .em_dst (em_dst),
    .mw_wr (mw_wr), .mw_dst (mw_dst),
    .ex_sel_a (ex_sel_a), .ex_sel_b (ex_sel_b),
    .id_sel_a (id_sel_a), .id_sel_b (id_sel_b)
  );

  function automatic logic [1:0] ref_sel(logic [AW-1:0] src);
    if (em_wr && em_dst != '0 && em_dst == src) return 2'b10;
    if (mw_wr && mw_dst != '0 && mw_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " ex_a"}, ex_sel_a, ref_sel(ex_src_a));
    chk({tag, " ex_b"}, ex_sel_b, ref_sel(ex_src_b));
    chk({tag, " id_a"}, id_sel_a, ref_sel(id_src_a));
    chk({tag, " id_b"}, id_sel_b, ref_sel(id_src_b));
  endtask

  task automatic drive(logic ew, logic [AW-1:0] ed, logic mwv, logic [AW-1:0] md,
                       logic [AW-1:0] ea, logic [AW-1:0] eb,
                       logic [AW-1:0] ia, logic [AW-1:0] ib);
    @(negedge clk);
    em_wr = ew; em_dst = ed; mw_wr = mwv; mw_dst = md;
    ex_src_a = ea; ex_src_b = eb; id_src_a = ia; id_src_b = ib;
    #1;
  endtask

  function automatic logic [AW-1:0] pick_reg();
    if ($urandom_range(3) != 0) return AW'($urandom_range(3));
    return AW'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7 idle state: nothing writes, all selects pass the register file
    chk("R7 idle ex_a", ex_sel_a, 2'b00);
    chk("R7 idle id_b", id_sel_b, 2'b00);

    // R1 execute/memory match on operand A, R9 same-cycle response
    drive(1, 5'd3, 0, 5'd0, 5'd3, 5'd7, 5'd1, 5'd2);
    chk("R1 ex_a mem", ex_sel_a, 2'b10);
    chk("R9 ex_b unaffected", ex_sel_b, 2'b00);

    // R2 memory/writeback match on operand B
    drive(1, 5'd4, 1, 5'd9, 5'd1, 5'd9, 5'd2, 5'd2);
    chk("R2 ex_b wb", ex_sel_b, 2'b01);

    // R3 both stages match: younger wins
    drive(1, 5'd6, 1, 5'd6, 5'd6, 5'd6, 5'd6, 5'd6);
    chk("R3 ex_a both", ex_sel_a, 2'b10);
    chk("R3 id_b both", id_sel_b, 2'b10);

    // R4 younger stage not writing: older still forwards
    drive(0, 5'd6, 1, 5'd6, 5'd6, 5'd1, 5'd6, 5'd1);
    chk("R4 ex_a falls to wb", ex_sel_a, 2'b01);
    // R4 neither stage writing
    drive(0, 5'd6, 0, 5'd6, 5'd6, 5'd6, 5'd6, 5'd6);
    chk("R4 ex_b no write", ex_sel_b, 2'b00);

    // R5 register 0 is never forwarded
    drive(1, 5'd0, 1, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0);
    chk("R5 ex_a zero", ex_sel_a, 2'b00);
    chk("R5 id_a zero", id_sel_a, 2'b00);
    // R5 younger to zero, older to nonzero register
    drive(1, 5'd0, 1, 5'd8, 5'd8, 5'd0, 5'd8, 5'd0);
    chk("R5 ex_a old forwards", ex_sel_a, 2'b01);

    // R6 decode comparator selects
    drive(1, 5'd12, 1, 5'd13, 5'd1, 5'd2, 5'd12, 5'd13);
    chk("R6 id_a mem", id_sel_a, 2'b10);
    chk("R6 id_b wb", id_sel_b, 2'b01);

    // R8 each select independent of the others
    drive(1, 5'd31, 1, 5'd30, 5'd31, 5'd30, 5'd5, 5'd31);
    chk("R8 ex_a", ex_sel_a, 2'b10);
    chk("R8 ex_b", ex_sel_b, 2'b01);
    chk("R8 id_a", id_sel_a, 2'b00);
    chk("R8 id_b", id_sel_b, 2'b10);

    // R1 R2 R3 R6 R7 R8 constrained random with heavy register collisions
    for (int n = 0; n < 3000; n++) begin
      drive(1'($urandom), pick_reg(), 1'($urandom), pick_reg(),
            pick_reg(), pick_reg(), pick_reg(), pick_reg());
      chk_all("R1-R8 random");
      if (ex_sel_a == 2'b11 || id_sel_b == 2'b11) chk("R7 no 11", 2'b11, 2'b00);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule